// File: doc/BRIEF.md
# Register Window Pointer Controller

This block keeps the pointers that select the active register window in a processor whose register file is split into eight overlapping windows. A 13-bit status word holds the current window pointer, the saved window pointer and a supervisor-mode bit. A procedure call moves the current pointer one window down. A return moves it one window up. Both wrap modulo the window count.

A call that would land the current pointer on the saved pointer is refused. The pointer keeps its old value, and a window-overflow trap is raised with its vector address. A relative jump whose computed target is odd raises an alignment trap instead. Software can write the status word, but a write only becomes visible one cycle later than a normal update. Software can also read the status word back as a full 32-bit value.

The interrupt forms of call and return, and the status write, need supervisor mode. In user mode they are dropped and an illegal-operation pulse is raised. Requests arrive as a 3-bit operation code, one per cycle. Every result appears on registered outputs one clock edge after the request.

Top module: `winptr_ctl`

## Requirements
- R1: Operation code 1 (call) and code 2 (interrupt call) decrement the current window pointer modulo 8 at the next edge. The pointer is status bits 2..0.
- R2: Operation code 3 (return) and code 4 (interrupt return) increment the current window pointer modulo 8, so 7 wraps to 0.
- R3: A call whose decremented pointer equals the saved pointer (status bits 5..3) leaves the current pointer unchanged. It also gives a one-cycle `ovf_trap` pulse with `trap_vec` = 0x80000020.
- R4: Operation code 7 (relative jump) with `jmp_target` bit 0 set gives a one-cycle `align_trap` pulse with `trap_vec` = 0x80000000. An even target raises no trap and leaves the status word unchanged.
- R5: Operation code 5 (status write) keeps only bits 12..0 of `wr_data`. The new word is not visible after the first edge. It appears on `status` after the second edge.
- R6: Operation code 6 (status read) gives a one-cycle `rd_valid` pulse. `rd_data` has bits 31..13 all ones and bits 12..0 equal to the status word from before the edge.
- R7: While status bit 6 (supervisor) is 0, codes 2, 4 and 5 leave the status word unchanged and give a one-cycle `illegal` pulse. Code 1 still acts.
- R8: After reset the status word is 0x048 (current pointer 0, saved pointer 1, supervisor 1). All trap, read and illegal outputs are 0, and `trap_vec` is 0.
- R9: The `cwp` output always equals status bits 2..0.
- R10: If a status write is still pending, the written word replaces the status word at the next edge. It overrides any pointer change made by a request in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_code | input | 3 | Request: 0 none, 1 call, 2 interrupt call, 3 return, 4 interrupt return, 5 status write, 6 status read, 7 relative jump |
| wr_data | input | 32 | Value for a status write |
| jmp_target | input | 32 | Computed target of a relative jump |
| cwp | output | 3 | Current window pointer |
| status | output | 13 | Status word |
| rd_valid | output | 1 | Status read result valid |
| rd_data | output | 32 | Status read result, upper bits ones |
| ovf_trap | output | 1 | Window-overflow trap pulse |
| align_trap | output | 1 | Jump alignment trap pulse |
| trap_vec | output | 32 | Trap vector address, 0 when no trap |
| illegal | output | 1 | Privileged request refused in user mode |

## Verification
Directed call runs walk the pointer down from 0 through the wrap to 7 and on until the saved pointer blocks it. This separates a plain wrap from an overflow refusal. Returns walk it back up across the 7-to-0 wrap. A status write is followed once by an idle cycle and once by a call in the very next cycle, which separates the one-cycle delay from an immediate write and shows that the pending write wins. User-mode sequences then try each privileged code and an unprivileged call. A long random mix of all codes, with random write data and targets, is compared against a bench model of the pointers, the pending write and the traps.

// File: rtl/winptr_pkg.sv
package winptr_pkg;
    typedef enum logic [2:0] {
        OP_NONE  = 3'd0,
        OP_CALL  = 3'd1,
        OP_CALLI = 3'd2,
        OP_RET   = 3'd3,
        OP_RETI  = 3'd4,
        OP_STWR  = 3'd5,
        OP_STRD  = 3'd6,
        OP_JMPR  = 3'd7
    } wp_op_e;

    typedef struct packed {
        logic call;
        logic ret;
        logic wr;
        logic rd;
        logic jmp;
        logic illegal;
    } wp_dec_t;
endpackage

// File: rtl/winptr_decode.sv
module winptr_decode
    import winptr_pkg::*;
(
    input  logic [2:0] op,
    input  logic       priv,
    output wp_dec_t    dec
);
    wp_op_e op_e;
    logic   needs_priv;

    assign op_e = wp_op_e'(op);

    always_comb begin
        needs_priv = (op_e == OP_CALLI) || (op_e == OP_RETI) || (op_e == OP_STWR);
        dec = '0;
        if (needs_priv && !priv) begin
            dec.illegal = 1'b1;
        end else begin
            case (op_e)
                OP_CALL, OP_CALLI: dec.call = 1'b1;
                OP_RET,  OP_RETI:  dec.ret  = 1'b1;
                OP_STWR:           dec.wr   = 1'b1;
                OP_STRD:           dec.rd   = 1'b1;
                OP_JMPR:           dec.jmp  = 1'b1;
                default:           dec      = '0;
            endcase
        end
    end
endmodule

// File: rtl/winptr_step.sv
module winptr_step #(
    parameter int NWIN  = 8,
    parameter int PTR_W = $clog2(NWIN)
) (
    input  logic [PTR_W-1:0] cur,
    input  logic [PTR_W-1:0] saved,
    input  logic             call,
    input  logic             ret,
    output logic [PTR_W-1:0] nxt,
    output logic             ovf
);
    logic [PTR_W-1:0] dn;
    logic [PTR_W-1:0] up;

    generate
        if ((1 << PTR_W) == NWIN) begin : g_pow2
            assign dn = cur - PTR_W'(1);
            assign up = cur + PTR_W'(1);
        end else begin : g_wrap
            assign dn = (cur == '0) ? PTR_W'(NWIN - 1) : cur - PTR_W'(1);
            assign up = (cur == PTR_W'(NWIN - 1)) ? '0 : cur + PTR_W'(1);
        end
    endgenerate

    always_comb begin
        ovf = call && (dn == saved);
        if (call) nxt = ovf ? cur : dn;
        else if (ret) nxt = up;
        else nxt = cur;
    end
endmodule

// File: rtl/winptr_ctl.sv
module winptr_ctl
    import winptr_pkg::*;
#(
    parameter int NWIN      = 8,
    parameter int DATA_W    = 32,
    parameter int ST_W      = 13,
    parameter int RST_CWP   = 0,
    parameter int RST_SWP   = 1,
    parameter logic [31:0] OVF_VEC   = 32'h8000_0020,
    parameter logic [31:0] ALIGN_VEC = 32'h8000_0000,
    localparam int PTR_W    = $clog2(NWIN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        op_code,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [DATA_W-1:0] jmp_target,
    output logic [PTR_W-1:0]  cwp,
    output logic [ST_W-1:0]   status,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              ovf_trap,
    output logic              align_trap,
    output logic [DATA_W-1:0] trap_vec,
    output logic              illegal
);
    localparam int CWP_LSB  = 0;
    localparam int SWP_LSB  = PTR_W;
    localparam int PRIV_BIT = 2 * PTR_W;
    localparam logic [ST_W-1:0] RST_WORD =
        ST_W'((RST_CWP << CWP_LSB) | (RST_SWP << SWP_LSB) | (1 << PRIV_BIT));

    typedef struct packed {
        logic [ST_W-1:0]   st;
        logic              pend;
        logic [ST_W-1:0]   pdat;
        logic              rdv;
        logic [DATA_W-1:0] rdd;
        logic              ovf;
        logic              aln;
        logic [DATA_W-1:0] vec;
        logic              ill;
    } state_t;

    state_t           s_d, s_q;
    wp_dec_t          dec;
    logic [PTR_W-1:0] ptr_nxt;
    logic             ptr_ovf;
    logic [ST_W-1:0]  st_upd;
    logic             pend_q;

    winptr_decode u_dec (
        .op   (op_code),
        .priv (s_q.st[PRIV_BIT]),
        .dec  (dec)
    );

    winptr_step #(.NWIN(NWIN), .PTR_W(PTR_W)) u_step (
        .cur   (s_q.st[CWP_LSB +: PTR_W]),
        .saved (s_q.st[SWP_LSB +: PTR_W]),
        .call  (dec.call),
        .ret   (dec.ret),
        .nxt   (ptr_nxt),
        .ovf   (ptr_ovf)
    );

    always_comb begin
        s_d     = s_q;
        s_d.rdv = 1'b0;
        s_d.ovf = 1'b0;
        s_d.aln = 1'b0;
        s_d.vec = '0;
        s_d.ill = dec.illegal;

        st_upd = s_q.st;
        st_upd[CWP_LSB +: PTR_W] = ptr_nxt;

        if (dec.rd) begin
            s_d.rdv = 1'b1;
            s_d.rdd = {{(DATA_W-ST_W){1'b1}}, s_q.st};
        end
        if (dec.jmp && jmp_target[0]) begin
            s_d.aln = 1'b1;
            s_d.vec = DATA_W'(ALIGN_VEC);
        end
        if (ptr_ovf) begin
            s_d.ovf = 1'b1;
            s_d.vec = DATA_W'(OVF_VEC);
        end

        s_d.pend = dec.wr;
        if (dec.wr) s_d.pdat = wr_data[ST_W-1:0];

        s_d.st = s_q.pend ? s_q.pdat : st_upd;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q    <= '0;
            s_q.st <= RST_WORD;
        end else begin
            s_q <= s_d;
        end
    end

    assign pend_q     = s_q.pend;
    assign status     = s_q.st;
    assign cwp        = s_q.st[CWP_LSB +: PTR_W];
    assign rd_valid   = s_q.rdv;
    assign rd_data    = s_q.rdd;
    assign ovf_trap   = s_q.ovf;
    assign align_trap = s_q.aln;
    assign trap_vec   = s_q.vec;
    assign illegal    = s_q.ill;
endmodule

// File: rtl/winptr_ctl_chk.sv
module winptr_ctl_chk #(
    parameter int PTR_W  = 3,
    parameter int DATA_W = 32,
    parameter int ST_W   = 13,
    parameter logic [31:0] OVF_VEC   = 32'h8000_0020,
    parameter logic [31:0] ALIGN_VEC = 32'h8000_0000
) (
    input logic              clk,
    input logic              rst_n,
    input logic [PTR_W-1:0]  cwp,
    input logic [ST_W-1:0]   status,
    input logic              rd_valid,
    input logic [DATA_W-1:0] rd_data,
    input logic              ovf_trap,
    input logic              align_trap,
    input logic [DATA_W-1:0] trap_vec,
    input logic              illegal,
    input logic              pend
);
    // R1 and R2: without a pending write the pointer moves by at most one
    a_r1_r2_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(pend) && cwp != $past(cwp)) |->
        (cwp == PTR_W'($past(cwp) + PTR_W'(1)) || cwp == PTR_W'($past(cwp) - PTR_W'(1))));

    a_r3_trap_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_trap && !$past(pend)) |-> cwp == $past(cwp));

    a_r3_ovf_vec: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_trap |-> trap_vec == DATA_W'(OVF_VEC));

    a_r4_align_vec: assert property (@(posedge clk) disable iff (!rst_n)
        align_trap |-> trap_vec == DATA_W'(ALIGN_VEC));

    a_r6_read_word: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (rd_data[DATA_W-1:ST_W] == '1 && rd_data[ST_W-1:0] == $past(status)));

    // R7: a refused request raises nothing else
    a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ovf_trap, align_trap, illegal}));

    a_r9_cwp_field: assert property (@(posedge clk) disable iff (!rst_n)
        cwp == status[PTR_W-1:0]);
endmodule

bind winptr_ctl winptr_ctl_chk #(
    .PTR_W(PTR_W), .DATA_W(DATA_W), .ST_W(ST_W),
    .OVF_VEC(OVF_VEC), .ALIGN_VEC(ALIGN_VEC)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cwp        (cwp),
    .status     (status),
    .rd_valid   (rd_valid),
    .rd_data    (rd_data),
    .ovf_trap   (ovf_trap),
    .align_trap (align_trap),
    .trap_vec   (trap_vec),
    .illegal    (illegal),
    .pend       (pend_q)
);

// File: tb/sim_winptr_ctl.sv
`timescale 1ns/1ps
module sim_winptr_ctl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  op_code = 3'd0;
    logic [31:0] wr_data = '0;
    logic [31:0] jmp_target = '0;
    logic [2:0]  cwp;
    logic [12:0] status;
    logic        rd_valid;
    logic [31:0] rd_data;
    logic        ovf_trap;
    logic        align_trap;
    logic [31:0] trap_vec;
    logic        illegal;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // bench model
    logic [12:0] m_st;
    logic        m_pend;
    logic [12:0] m_pdat;
    logic        e_rdv, e_ovf, e_aln, e_ill;
    logic [31:0] e_rdd, e_vec;
    string       e_tag;

    always #5 clk = ~clk;

    winptr_ctl u0 (
        .clk(clk), .rst_n(rst_n), .op_code(op_code), .wr_data(wr_data),
        .jmp_target(jmp_target), .cwp(cwp), .status(status), .rd_valid(rd_valid),
        .rd_data(rd_data), .ovf_trap(ovf_trap), .align_trap(align_trap),
        .trap_vec(trap_vec), .illegal(illegal)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_st = 13'h048; m_pend = 0; m_pdat = '0;
        e_rdv = 0; e_rdd = '0; e_ovf = 0; e_aln = 0; e_ill = 0; e_vec = '0;
    endtask

    task automatic model_edge(input logic [2:0] op, input logic [31:0] wd, input logic [31:0] tg);
        logic [2:0]  c, s, dn;
        logic        priv, needp, npend;
        logic [12:0] nst, npdat;
        c = m_st[2:0]; s = m_st[5:3]; priv = m_st[6];
        dn = c - 3'd1;
        needp = (op == 3'd2) || (op == 3'd4) || (op == 3'd5);
        nst = m_st; npend = 0; npdat = m_pdat;
        e_rdv = 0; e_ovf = 0; e_aln = 0; e_vec = '0;
        e_ill = needp && !priv;
        e_tag = "R9";
        if (e_ill) e_tag = "R7";
        else case (op)
            3'd1, 3'd2: begin
                if (dn == s) begin e_ovf = 1; e_vec = 32'h8000_0020; e_tag = "R3"; end
                else begin nst[2:0] = dn; e_tag = "R1"; end
            end
            3'd3, 3'd4: begin nst[2:0] = c + 3'd1; e_tag = "R2"; end
            3'd5: begin npend = 1; npdat = wd[12:0]; e_tag = "R5"; end
            3'd6: begin e_rdv = 1; e_rdd = {19'h7FFFF, m_st}; e_tag = "R6"; end
            3'd7: begin
                e_tag = "R4";
                if (tg[0]) begin e_aln = 1; e_vec = 32'h8000_0000; end
            end
            default: e_tag = "R9";
        endcase
        if (m_pend) e_tag = "R10";
        m_st = m_pend ? m_pdat : nst;
        m_pend = npend; m_pdat = npdat;
    endtask

    task automatic compare_all(input string tag);
        chk(tag, {19'd0, status}, {19'd0, m_st});
        chk("R9", {29'd0, cwp}, {29'd0, status[2:0]});
        chk(tag, {31'd0, ovf_trap}, {31'd0, e_ovf});
        chk(tag, {31'd0, align_trap}, {31'd0, e_aln});
        chk(tag, trap_vec, e_vec);
        chk(tag, {31'd0, illegal}, {31'd0, e_ill});
        chk(tag, {31'd0, rd_valid}, {31'd0, e_rdv});
        if (e_rdv) chk(tag, rd_data, e_rdd);
    endtask

    // called at a falling edge; returns at the next falling edge
    task automatic step(input logic [2:0] op, input logic [31:0] wd, input logic [31:0] tg);
        op_code = op; wr_data = wd; jmp_target = tg;
        @(posedge clk);
        model_edge(op, wd, tg);
        @(negedge clk);
        compare_all(e_tag);
    endtask

    task automatic do_reset();
        rst_n = 0; op_code = 3'd0;
        repeat (2) @(negedge clk);
        model_reset();
        rst_n = 1;
        // R8: reset state
        chk("R8", {19'd0, status}, 32'h048);
        chk("R8", {29'd0, cwp}, 32'd0);
        chk("R8", {29'd0, ovf_trap, align_trap, illegal}, 32'd0);
        chk("R8", trap_vec, 32'd0);
        chk("R8", {31'd0, rd_valid}, 32'd0);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] rv;
        void'($urandom(32'd1234));
        @(negedge clk);
        do_reset();

        // R1 wrap 0 -> 7 then down; R3 refusal at saved pointer 1
        for (int i = 0; i < 7; i++) step(3'd1, '0, '0);
        chk("R3", {29'd0, cwp}, 32'd2);
        chk("R3", {31'd0, ovf_trap}, 32'd1);
        step(3'd0, '0, '0);
        chk("R3", {31'd0, ovf_trap}, 32'd0);
        // R2 back up and across the 7 -> 0 wrap
        for (int i = 0; i < 6; i++) step(3'd4, '0, '0);
        chk("R2", {29'd0, cwp}, 32'd0);
        step(3'd1, '0, '0);
        step(3'd3, '0, '0);
        chk("R2", {29'd0, cwp}, 32'd0);

        // R4 odd and even jump targets
        step(3'd7, '0, 32'h0000_1235);
        chk("R4", {31'd0, align_trap}, 32'd1);
        step(3'd7, '0, 32'h0000_1234);
        chk("R4", {31'd0, align_trap}, 32'd0);

        // R5 delayed write, upper bits dropped; R6 read back
        step(3'd5, 32'hFFFF_E0C5, '0);
        chk("R5", {19'd0, status}, 32'h048);
        step(3'd0, '0, '0);
        chk("R5", {19'd0, status}, 32'h0C5);
        step(3'd6, '0, '0);
        chk("R6", rd_data, 32'hFFFF_E0C5);

        // R10 write followed at once by a call: the write wins
        step(3'd5, 32'h0000_0053, '0);
        step(3'd1, '0, '0);
        chk("R10", {19'd0, status}, 32'h053);

        // R7 user mode: privileged codes refused, plain call still acts
        step(3'd5, 32'h0000_000B, '0);
        step(3'd0, '0, '0);
        step(3'd2, '0, '0);
        chk("R7", {31'd0, illegal}, 32'd1);
        chk("R7", {19'd0, status}, 32'h00B);
        step(3'd4, '0, '0);
        step(3'd5, 32'h0000_0040, '0);
        step(3'd0, '0, '0);
        chk("R7", {19'd0, status}, 32'h00B);
        step(3'd1, '0, '0);
        chk("R7", {29'd0, cwp}, 32'd2);

        // random mix
        do_reset();
        for (int n = 0; n < 600; n++) begin
            rv = $urandom;
            if (n % 97 == 96) begin
                @(negedge clk);
                do_reset();
            end else begin
                logic [31:0] wd;
                wd = $urandom;
                if (rv[10:8] != 3'd0) wd[6] = 1'b1;
                step(rv[2:0], wd, $urandom);
            end
        end

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule